// File: doc/BRIEF.md
# Audio Channel Slot Remapper

This block steers up to eight audio sample channels onto eight outgoing link slots through a small programmable routing table. Software programs the table one entry at a time. Each write is a single packed byte that names a source channel and the slot it should land in. A separate register holds the active channel count, stored as the count minus one. A readback port indexed by channel returns each entry in the same packed byte form, and the stored count can also be read.

Programming goes into a staging copy of the table and the count. A frame-boundary pulse copies the staging state into the working copy, so a frame of samples is always routed with one consistent table. For each valid frame, the crossbar takes one sample per channel and places it in the slot that channel is routed to. Several rules apply on the way:
- A channel at or above the programmed count is inactive.
- When two active channels target the same slot, the higher-numbered channel wins that slot.
- A slot that no active channel targets carries zero.

Top module: `slot_remapper`

## Requirements
- R1: After reset every channel n reads back as byte {n[3:0], 1'b0, n[2:0]}, which is the identity routing. The count register reads 1, meaning two channels.
- R2: A map write byte carries the source channel in bits 7:4 and the destination slot in bits 2:0. Bit 3 is ignored. On the cycle after the write, a readback of that channel returns the channel in bits 7:4, zero in bit 3 and the slot in bits 2:0.
- R3: A map write whose channel field is 8 or higher (bit 7 set) changes no table entry.
- R4: A count write stores a 3-bit value v, equal to the channel count minus one, and the count readback returns v on the next cycle. A write of v = 0 (a single channel, below the minimum of two) is ignored.
- R5: Map and count writes reach the sample path only at a frame-boundary pulse. A frame sent before the pulse is routed with the earlier table, even when that frame arrives after the write.
- R6: For each frame marked valid, the output is valid exactly one cycle later. Output slot s then carries the sample of the active channel routed to s.
- R7: An output slot that no active channel is routed to is driven with zero.
- R8: A channel whose index is greater than the stored count value is inactive and reaches no slot.
- R9: When two or more active channels route to the same slot, the sample of the highest-numbered of them appears in that slot.
- R10: With no programming after reset, only slots 0 and 1 carry channels 0 and 1. Slots 2 to 7 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Map write strobe |
| map_wr_byte | input | 8 | Packed write: channel in 7:4, slot in 2:0 |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_val | input | 3 | Channel count minus one |
| rd_ch | input | 3 | Channel index for readback |
| rd_byte | output | 8 | Packed entry of the indexed channel |
| cnt_rd | output | 3 | Stored count value (count minus one) |
| frame_sync | input | 1 | Frame boundary pulse, commits staging state |
| samp_valid | input | 1 | Input frame valid |
| samp_in | input | NUM_CH*SAMPLE_W | Input samples, channel c at bits c*SAMPLE_W upward |
| out_valid | output | 1 | Output frame valid |
| samp_out | output | NUM_CH*SAMPLE_W | Output samples, slot s at bits s*SAMPLE_W upward |

## Verification
The bench builds the block with its defaults: eight channels, 16-bit samples and the registered output variant. At these values the 4-bit channel field can name channels 8 to 15, which do not exist in the table. The channel count can also cover its whole legal span, from two to eight. Because each channel carries a distinct nonzero sample, any misrouted slot, leaked inactive channel, wrong collision winner or early table commit appears as a mismatch in the scoreboard.

// File: rtl/remap_pkg.sv
package remap_pkg;
   localparam int BYTE_W  = 8;
   localparam int SLOT_W  = 3;
   localparam int CHF_W   = 4;
   localparam int MAX_CH  = 8;

   typedef logic [SLOT_W-1:0] slot_t;
   typedef logic [CHF_W-1:0]  chf_t;

   function automatic logic [BYTE_W-1:0] pack_entry(chf_t ch, slot_t sl);
      return {ch, 1'b0, sl};
   endfunction
endpackage

// File: rtl/remap_cmd_regs.sv
module remap_cmd_regs
   import remap_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     map_wr_en,
   input  logic [BYTE_W-1:0]        map_wr_byte,
   input  logic                     cnt_wr_en,
   input  logic [SLOT_W-1:0]        cnt_wr_val,
   input  logic [SLOT_W-1:0]        rd_ch,
   output logic [BYTE_W-1:0]        rd_byte,
   output logic [SLOT_W-1:0]        cnt_rd,
   output logic [NUM_CH*SLOT_W-1:0] shadow_map_o,
   output logic [SLOT_W-1:0]        shadow_cnt_o
);
   localparam logic [CHF_W-1:0] CH_LIMIT = CHF_W'(NUM_CH);

   initial begin
      if (NUM_CH < 2 || NUM_CH > MAX_CH)
         $error("remap_cmd_regs: NUM_CH must lie in 2..8");
   end

   chf_t  wr_ch;
   slot_t wr_slot;
   logic  wr_ok;
   logic  cnt_ok;
   logic  unused_pad_bit;
   slot_t tbl [NUM_CH];
   slot_t cnt_q;
   slot_t rd_slot;

   assign wr_ch          = map_wr_byte[7:4];
   assign wr_slot        = map_wr_byte[2:0];
   assign unused_pad_bit = map_wr_byte[3];
   assign wr_ok  = map_wr_en && (wr_ch < CH_LIMIT) && ({1'b0, wr_slot} < CH_LIMIT);
   assign cnt_ok = cnt_wr_en && (cnt_wr_val != '0) && ({1'b0, cnt_wr_val} < CH_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) tbl[i] <= SLOT_W'(i);
      end else if (wr_ok) begin
         for (int i = 0; i < NUM_CH; i++)
            if (wr_ch == CHF_W'(i)) tbl[i] <= wr_slot;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= SLOT_W'(1);
      else if (cnt_ok) cnt_q <= cnt_wr_val;
   end

   always_comb begin
      rd_slot = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (rd_ch == SLOT_W'(i)) rd_slot = tbl[i];
   end

   assign rd_byte      = pack_entry({1'b0, rd_ch}, rd_slot);
   assign cnt_rd       = cnt_q;
   assign shadow_cnt_o = cnt_q;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
      assign shadow_map_o[g*SLOT_W +: SLOT_W] = tbl[g];

      // R2: a legal write lands in its entry on the next cycle
      p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (map_wr_en && map_wr_byte[7:4] == CHF_W'(g) && ({1'b0, map_wr_byte[2:0]} < CH_LIMIT))
         |=> tbl[g] == $past(map_wr_byte[2:0]));
   end

   // R3: channel field beyond the table leaves every entry alone
   p_hi_ch_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr_en && map_wr_byte[7]) |=> $stable(shadow_map_o));

   // R4: a zero count value is refused
   p_zero_cnt_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_en && cnt_wr_val == '0) |=> $stable(cnt_rd));

   // R4: the stored value never drops to one channel
   p_cnt_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rd != '0);
endmodule

// File: rtl/remap_frame_latch.sv
module remap_frame_latch
   import remap_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_sync,
   input  logic [NUM_CH*SLOT_W-1:0] shadow_map_i,
   input  logic [SLOT_W-1:0]        shadow_cnt_i,
   output logic [NUM_CH*SLOT_W-1:0] act_map_o,
   output logic [SLOT_W-1:0]        act_cnt_o
);
   logic [NUM_CH*SLOT_W-1:0] ident;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ident
      assign ident[g*SLOT_W +: SLOT_W] = SLOT_W'(g);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_map_o <= ident;
         act_cnt_o <= SLOT_W'(1);
      end else if (frame_sync) begin
         act_map_o <= shadow_map_i;
         act_cnt_o <= shadow_cnt_i;
      end
   end

   // R5: working table only moves at a frame boundary
   p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_sync |=> ($stable(act_map_o) && $stable(act_cnt_o)));

   // R5: a boundary copies the staging state
   p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> (act_map_o == $past(shadow_map_i) && act_cnt_o == $past(shadow_cnt_i)));
endmodule

// File: rtl/remap_xbar.sv
module remap_xbar
   import remap_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int SAMPLE_W = 16,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       samp_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0] samp_in,
   input  logic [NUM_CH*SLOT_W-1:0]   act_map,
   input  logic [SLOT_W-1:0]          act_cnt,
   output logic                       out_valid,
   output logic [NUM_CH*SAMPLE_W-1:0] samp_out
);
   initial begin
      if (SAMPLE_W < 1)
         $error("remap_xbar: SAMPLE_W must be positive");
   end

   logic [NUM_CH*SAMPLE_W-1:0] xb_flat;

   // ascending scan: a later (higher) channel overwrites an earlier one
   always_comb begin
      xb_flat = '0;
      for (int s = 0; s < NUM_CH; s++) begin
         for (int c = 0; c < NUM_CH; c++) begin
            if ((SLOT_W'(c) <= act_cnt) && (act_map[c*SLOT_W +: SLOT_W] == SLOT_W'(s)))
               xb_flat[s*SAMPLE_W +: SAMPLE_W] = samp_in[c*SAMPLE_W +: SAMPLE_W];
         end
      end
   end

   if (REG_OUT) begin : g_reg
      logic                       vld_q;
      logic [NUM_CH*SAMPLE_W-1:0] dat_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else begin
            vld_q <= samp_valid;
            if (samp_valid) dat_q <= xb_flat;
         end
      end

      assign out_valid = vld_q;
      assign samp_out  = dat_q;

      // R6: each input frame yields one output frame a cycle later
      p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
         samp_valid |=> out_valid);

      p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !samp_valid |=> !out_valid);

      // R6: output data holds while no frame arrives
      p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !samp_valid |=> $stable(samp_out));
   end else begin : g_comb
      assign out_valid = samp_valid;
      assign samp_out  = xb_flat;
   end
endmodule

// File: rtl/slot_remapper.sv
module slot_remapper
   import remap_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int SAMPLE_W = 16,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       map_wr_en,
   input  logic [7:0]                 map_wr_byte,
   input  logic                       cnt_wr_en,
   input  logic [2:0]                 cnt_wr_val,
   input  logic [2:0]                 rd_ch,
   output logic [7:0]                 rd_byte,
   output logic [2:0]                 cnt_rd,
   input  logic                       frame_sync,
   input  logic                       samp_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0] samp_in,
   output logic                       out_valid,
   output logic [NUM_CH*SAMPLE_W-1:0] samp_out
);
   localparam int MAP_W = NUM_CH * SLOT_W;

   logic [MAP_W-1:0]  shadow_map;
   logic [SLOT_W-1:0] shadow_cnt;
   logic [MAP_W-1:0]  act_map;
   logic [SLOT_W-1:0] act_cnt;

   remap_cmd_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .map_wr_en    (map_wr_en),
      .map_wr_byte  (map_wr_byte),
      .cnt_wr_en    (cnt_wr_en),
      .cnt_wr_val   (cnt_wr_val),
      .rd_ch        (rd_ch),
      .rd_byte      (rd_byte),
      .cnt_rd       (cnt_rd),
      .shadow_map_o (shadow_map),
      .shadow_cnt_o (shadow_cnt)
   );

   remap_frame_latch #(.NUM_CH(NUM_CH)) u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_sync   (frame_sync),
      .shadow_map_i (shadow_map),
      .shadow_cnt_i (shadow_cnt),
      .act_map_o    (act_map),
      .act_cnt_o    (act_cnt)
   );

   remap_xbar #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .REG_OUT(REG_OUT)) u_xbar (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_valid (samp_valid),
      .samp_in    (samp_in),
      .act_map    (act_map),
      .act_cnt    (act_cnt),
      .out_valid  (out_valid),
      .samp_out   (samp_out)
   );
endmodule

// File: tb/tb_slot_remapper.sv
module tb_slot_remapper;
   localparam int NCH = 8;
   localparam int SW  = 16;
   localparam int VW  = NCH * SW;

   typedef struct {
      logic [VW-1:0] exp;
      string         req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          map_wr_en = 1'b0;
   logic [7:0]    map_wr_byte = '0;
   logic          cnt_wr_en = 1'b0;
   logic [2:0]    cnt_wr_val = '0;
   logic [2:0]    rd_ch = '0;
   logic [7:0]    rd_byte;
   logic [2:0]    cnt_rd;
   logic          frame_sync = 1'b0;
   logic          samp_valid = 1'b0;
   logic [VW-1:0] samp_in = '0;
   logic          out_valid;
   logic [VW-1:0] samp_out;

   int     n_checks = 0;
   int     n_errors = 0;
   int     cyc = 0;
   item_t  sb[$];
   int     m_sh [NCH];
   int     m_act [NCH];
   int     m_shcnt = 1;
   int     m_actcnt = 1;

   always #2 clk = ~clk;

   slot_remapper #(.NUM_CH(NCH), .SAMPLE_W(SW), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .map_wr_en(map_wr_en), .map_wr_byte(map_wr_byte),
      .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val),
      .rd_ch(rd_ch), .rd_byte(rd_byte), .cnt_rd(cnt_rd),
      .frame_sync(frame_sync), .samp_valid(samp_valid), .samp_in(samp_in),
      .out_valid(out_valid), .samp_out(samp_out)
   );

   task automatic map_write(input logic [7:0] b);
      @(negedge clk);
      map_wr_en = 1'b1; map_wr_byte = b;
      if (!b[7]) m_sh[b[6:4]] = int'(b[2:0]);
      @(negedge clk);
      map_wr_en = 1'b0;
   endtask

   task automatic cnt_write(input logic [2:0] v);
      @(negedge clk);
      cnt_wr_en = 1'b1; cnt_wr_val = v;
      if (v != 3'd0) m_shcnt = int'(v);
      @(negedge clk);
      cnt_wr_en = 1'b0;
   endtask

   task automatic sync_pulse();
      @(negedge clk);
      frame_sync = 1'b1;
      for (int c = 0; c < NCH; c++) m_act[c] = m_sh[c];
      m_actcnt = m_shcnt;
      @(negedge clk);
      frame_sync = 1'b0;
   endtask

   task automatic send_frame(input int k, input string req);
      item_t         it;
      logic [VW-1:0] v;
      for (int c = 0; c < NCH; c++) v[c*SW +: SW] = SW'((c + 1) * 16'h1000 + k);
      it.exp = '0;
      for (int s = 0; s < NCH; s++)
         for (int c = 0; c < NCH; c++)
            if (c <= m_actcnt && m_act[c] == s) it.exp[s*SW +: SW] = v[c*SW +: SW];
      it.req = req;
      @(negedge clk);
      samp_valid = 1'b1; samp_in = v;
      sb.push_back(it);
      @(negedge clk);
      samp_valid = 1'b0;
   endtask

   task automatic check_rd(input int ch, input string req);
      logic [7:0] e;
      @(negedge clk);
      rd_ch = 3'(ch);
      #1;
      e = {4'(ch), 1'b0, 3'(m_sh[ch])};
      n_checks++;
      if (rd_byte !== e) begin
         n_errors++;
         $display("FAIL %s readback ch%0d: actual %02h expected %02h", req, ch, rd_byte, e);
      end
   endtask

   task automatic check_cnt(input string req);
      @(negedge clk);
      n_checks++;
      if (cnt_rd !== 3'(m_shcnt)) begin
         n_errors++;
         $display("FAIL %s count: actual %0d expected %0d", req, cnt_rd, m_shcnt);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_checks++;
         if (sb.size() == 0) begin
            n_errors++;
            $display("FAIL R6 unexpected output frame: actual %h expected none", samp_out);
         end else begin
            item_t it;
            it = sb.pop_front();
            if (samp_out !== it.exp) begin
               n_errors++;
               $display("FAIL %s frame: actual %h expected %h", it.req, samp_out, it.exp);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_errors++; n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin m_sh[c] = c; m_act[c] = c; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: identity readback and count of two
      for (int c = 0; c < NCH; c++) check_rd(c, "R1");
      check_cnt("R1");
      // R10: default routing passes only channels 0 and 1
      send_frame(1, "R10");
      // R4: eight channels; R5: not yet applied
      cnt_write(3'd7);
      check_cnt("R4");
      send_frame(2, "R5");
      sync_pulse();
      send_frame(3, "R6");
      // R2: bit 3 set is ignored, ch0 -> slot7
      map_write(8'h0F);
      check_rd(0, "R2");
      map_write(8'h70);
      check_rd(7, "R2");
      send_frame(4, "R5");
      sync_pulse();
      send_frame(5, "R6");
      send_frame(6, "R6");
      // R9 collision ch2/ch3 on slot 2, R7 slot 3 left empty
      map_write(8'h32);
      check_rd(3, "R2");
      sync_pulse();
      send_frame(7, "R9 R7");
      // R3: channel field 9 would alias ch1 if truncated
      map_write(8'h95);
      check_rd(1, "R3");
      sync_pulse();
      send_frame(8, "R3");
      // R4: zero refused
      cnt_write(3'd0);
      check_cnt("R4");
      // R8: four channels active
      cnt_write(3'd3);
      check_cnt("R4");
      sync_pulse();
      send_frame(9, "R8 R7");
      repeat (4) @(negedge clk);
      n_checks++;
      if (sb.size() != 0) begin
         n_errors++;
         $display("FAIL R6 missing frames: actual %0d pending expected 0", sb.size());
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule